// File: doc/BRIEF.md
# Embedded Register Data Line Encoder

This block builds the register-snapshot rows that a frame carries in its two rows just before the first active image row. Each row is a stream of 12-bit pixel words, one per clock, with line-valid held high. The row opens with an identifier word. It then gives the first address of each register range and the values of the 16-bit registers in that range. Every byte rides in the upper eight bits of a pixel word. Fixed marker words sit between the fields so that a receiver can lock onto the structure.

The frame controller pulses `start_i` once per embedded row. With the pulse it gives the row type on `line_sel_i` (first or second snapshot row) and the row width in words on `width_i`. The encoder then reads each register through a 16-bit-address read port with a fixed one-cycle latency. Each read is issued one cycle ahead, so the output runs without gaps. When the content is used up, the encoder pads with zero words to the programmed width. If the width is shorter than the content, the row is cut at the width.

Top module: `emb_line_enc`

## Requirements
- R1: During and after reset, `lv_o` is low, `pix_o` is zero and `rd_en_o` is low.
- R2: A `start_i` pulse while idle with nonzero `width_i` raises `lv_o` in the next cycle, and the first word is 0x0A0. `line_sel_i` (0 = first row, 1 = second row) and `width_i` are captured at the start.
- R3: An address header is the four words 0xAA0, {addr[15:8],4'h0}, 0xA50, {addr[7:0],4'h0}, where addr is the first register address of a range. One header follows the identifier word directly.
- R4: Each register is sent as four words: 0x5A0, {value[15:8],4'h0}, 0x5A0, {value[7:0],4'h0}.
- R5: Registers inside one range follow at address steps of +2 up to and including the range's last address, and the address is not repeated.
- R6: The first row covers 0x3000..0x312E, which is 613 content words. The second row covers 0x3136..0x31BE, then a fresh header and 0x31D0..0x31FE, which is 381 content words.
- R7: Each register's value is requested by a single `rd_en_o` cycle, with `rd_addr_o` set, in the cycle before its MSB word. The value returned on `rd_data_i` in the following cycle is forwarded unchanged, including zero for registers that do not exist.
- R8: `lv_o` stays high for exactly `width_i` cycles. Words after the content are zero, and content beyond the width is dropped.
- R9: `start_i` during an active row has no effect, and neither does `start_i` with `width_i` of zero.
- R10: Whenever `lv_o` is low, `pix_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one embedded row |
| line_sel_i | input | 1 | Row type: 0 first, 1 second |
| width_i | input | 16 | Row length in words |
| rd_en_o | output | 1 | Register read request |
| rd_addr_o | output | 16 | Register read address |
| rd_data_i | input | 16 | Register value, one cycle after the request |
| lv_o | output | 1 | Line valid |
| pix_o | output | 12 | Pixel word |

## Verification
A read issued in the wrong cycle puts a wrong MSB word on the bus in the very next cycle. The bench's register model returns a poison value outside read-data cycles, so this shows at once. A wrong range boundary or address step shows as a header or value word that differs at a known word index. A line-length counter error shows as `lv_o` falling one or more cycles early or late at the end of the row. Streams are compared word by word against an expected row built from the requirements alone.

// File: rtl/emb_pkg.sv
package emb_pkg;
  localparam int PIX_W  = 12;
  localparam int DATA_W = 16;

  localparam logic [PIX_W-1:0] W_ID    = 12'h0A0;
  localparam logic [PIX_W-1:0] W_AHDR  = 12'hAA0;
  localparam logic [PIX_W-1:0] W_AMID  = 12'hA50;
  localparam logic [PIX_W-1:0] W_VMARK = 12'h5A0;

  typedef enum logic [3:0] {
    K_ID, K_AHDR, K_AMSB, K_AMID, K_ALSB,
    K_VMARK1, K_VMSB, K_VMARK2, K_VLSB, K_FILL
  } word_kind_e;

  function automatic logic [PIX_W-1:0] pack_byte(input logic [7:0] b);
    return {b, {(PIX_W-8){1'b0}}};
  endfunction
endpackage

// File: rtl/emb_seq.sv
module emb_seq
  import emb_pkg::*;
#(
  parameter int          LW_W      = 16,
  parameter logic [15:0] L1_FIRST  = 16'h3000,
  parameter logic [15:0] L1_LAST   = 16'h312E,
  parameter logic [15:0] L2A_FIRST = 16'h3136,
  parameter logic [15:0] L2A_LAST  = 16'h31BE,
  parameter logic [15:0] L2B_FIRST = 16'h31D0,
  parameter logic [15:0] L2B_LAST  = 16'h31FE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            line_sel_i,
  input  logic [LW_W-1:0] width_i,
  output logic            active_o,
  output word_kind_e      kind_o,
  output logic [15:0]     addr_o,
  output logic            rd_en_o
);
  localparam int RI_W = 2;

  logic            active_q;
  word_kind_e      kind_q, kind_d;
  logic [LW_W-1:0] col_q, width_q;
  logic [RI_W-1:0] ridx_q, last_idx_q;
  logic [15:0]     addr_q;
  logic            range_end, more_ranges;

  function automatic logic [15:0] r_first(input logic [RI_W-1:0] i);
    case (i)
      2'd0:    return L1_FIRST;
      2'd1:    return L2A_FIRST;
      default: return L2B_FIRST;
    endcase
  endfunction

  function automatic logic [15:0] r_last(input logic [RI_W-1:0] i);
    case (i)
      2'd0:    return L1_LAST;
      2'd1:    return L2A_LAST;
      default: return L2B_LAST;
    endcase
  endfunction

  assign range_end   = (addr_q == r_last(ridx_q));
  assign more_ranges = (ridx_q != last_idx_q);

  always_comb begin
    kind_d = kind_q;
    unique case (kind_q)
      K_ID:     kind_d = K_AHDR;
      K_AHDR:   kind_d = K_AMSB;
      K_AMSB:   kind_d = K_AMID;
      K_AMID:   kind_d = K_ALSB;
      K_ALSB:   kind_d = K_VMARK1;
      K_VMARK1: kind_d = K_VMSB;
      K_VMSB:   kind_d = K_VMARK2;
      K_VMARK2: kind_d = K_VLSB;
      K_VLSB:   kind_d = !range_end ? K_VMARK1 : (more_ranges ? K_AHDR : K_FILL);
      K_FILL:   kind_d = K_FILL;
      default:  kind_d = K_FILL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      kind_q     <= K_FILL;
      col_q      <= '0;
      width_q    <= '0;
      ridx_q     <= '0;
      last_idx_q <= '0;
      addr_q     <= '0;
    end else if (!active_q) begin
      if (start_i && (width_i != '0)) begin
        active_q   <= 1'b1;
        kind_q     <= K_ID;
        col_q      <= '0;
        width_q    <= width_i;
        ridx_q     <= line_sel_i ? 2'd1 : 2'd0;
        last_idx_q <= line_sel_i ? 2'd2 : 2'd0;
        addr_q     <= line_sel_i ? L2A_FIRST : L1_FIRST;
      end
    end else begin
      col_q  <= col_q + 1'b1;
      kind_q <= kind_d;
      if (col_q == width_q - 1'b1) active_q <= 1'b0;
      if (kind_q == K_VLSB && !range_end) begin
        addr_q <= addr_q + 16'd2;
      end else if (kind_q == K_VLSB && more_ranges) begin
        ridx_q <= ridx_q + 1'b1;
        addr_q <= r_first(ridx_q + 1'b1);
      end
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;
  assign addr_o   = addr_q;
  assign rd_en_o  = active_q && (kind_q == K_VMARK1);

  // R8
  col_in_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (col_q < width_q));

  // R5
  addr_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (addr_q[0] == 1'b0));
endmodule

// File: rtl/emb_fmt.sv
module emb_fmt
  import emb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  word_kind_e        kind_i,
  input  logic [15:0]       addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [7:0] lsb_q;

  // value arrives for one cycle only; hold the low byte for the later word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             lsb_q <= '0;
    else if (active_i && kind_i == K_VMSB)   lsb_q <= rd_data_i[7:0];
  end

  always_comb begin
    pix_o = '0;
    if (active_i) begin
      unique case (kind_i)
        K_ID:     pix_o = W_ID;
        K_AHDR:   pix_o = W_AHDR;
        K_AMSB:   pix_o = pack_byte(addr_i[15:8]);
        K_AMID:   pix_o = W_AMID;
        K_ALSB:   pix_o = pack_byte(addr_i[7:0]);
        K_VMARK1: pix_o = W_VMARK;
        K_VMSB:   pix_o = pack_byte(rd_data_i[15:8]);
        K_VMARK2: pix_o = W_VMARK;
        K_VLSB:   pix_o = pack_byte(lsb_q);
        K_FILL:   pix_o = '0;
        default:  pix_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/emb_line_enc.sv
module emb_line_enc
  import emb_pkg::*;
#(
  parameter int          LW_W      = 16,
  parameter logic [15:0] L1_FIRST  = 16'h3000,
  parameter logic [15:0] L1_LAST   = 16'h312E,
  parameter logic [15:0] L2A_FIRST = 16'h3136,
  parameter logic [15:0] L2A_LAST  = 16'h31BE,
  parameter logic [15:0] L2B_FIRST = 16'h31D0,
  parameter logic [15:0] L2B_LAST  = 16'h31FE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              line_sel_i,
  input  logic [LW_W-1:0]   width_i,
  output logic              rd_en_o,
  output logic [15:0]       rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              lv_o,
  output logic [PIX_W-1:0]  pix_o
);
  logic        active;
  word_kind_e  kind;
  logic [15:0] addr;

  emb_seq #(
    .LW_W(LW_W), .L1_FIRST(L1_FIRST), .L1_LAST(L1_LAST),
    .L2A_FIRST(L2A_FIRST), .L2A_LAST(L2A_LAST),
    .L2B_FIRST(L2B_FIRST), .L2B_LAST(L2B_LAST)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .line_sel_i, .width_i,
    .active_o(active), .kind_o(kind), .addr_o(addr), .rd_en_o(rd_en_o)
  );

  emb_fmt u_fmt (
    .clk_i, .rst_ni, .active_i(active), .kind_i(kind),
    .addr_i(addr), .rd_data_i(rd_data_i), .pix_o(pix_o)
  );

  assign lv_o      = active;
  assign rd_addr_o = addr;

  // R2
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lv_o) |-> (pix_o == W_ID));

  // R7
  msb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && lv_o) |=> (!lv_o || pix_o == pack_byte(rd_data_i[15:8])));

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lv_o |-> (pix_o == '0));

  // R7
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
endmodule

// File: tb/emb_line_enc_test.sv
module emb_line_enc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {line_sel, width}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'd1280}, {1'b1, 16'd1280}, {1'b0, 16'd613}, {1'b1, 16'd381},
    {1'b1, 16'd200},  {1'b0, 16'd1},    {1'b1, 16'd390}, {1'b0, 16'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        line_sel = 1'b0;
  logic [15:0] width = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [15:0] rd_data;
  logic        lv;
  logic [11:0] pix;

  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_mem [0:2047];

  always #(CLK_PERIOD/2) clk = ~clk;

  emb_line_enc uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .line_sel_i(line_sel),
    .width_i(width), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .lv_o(lv), .pix_o(pix)
  );

  // addresses with bits [3:1] == 5 are treated as unimplemented
  function automatic logic [15:0] mem_val(input logic [15:0] a);
    logic [15:0] p;
    p = a * 16'h0107;
    return (a[3:1] == 3'd5) ? 16'h0000 : (p ^ 16'h5A3C);
  endfunction

  always_ff @(posedge clk) rd_data <= rd_en ? mem_val(rd_addr) : 16'hDEAD;

  task automatic build(input logic sel);
    int n = 0;
    int nr;
    logic [15:0] f [2];
    logic [15:0] l [2];
    if (sel) begin f[0] = 16'h3136; l[0] = 16'h31BE; f[1] = 16'h31D0; l[1] = 16'h31FE; nr = 2; end
    else     begin f[0] = 16'h3000; l[0] = 16'h312E; f[1] = 16'h0;    l[1] = 16'h0;    nr = 1; end
    exp_mem[n++] = 12'h0A0;
    for (int r = 0; r < nr; r++) begin
      exp_mem[n++] = 12'hAA0; exp_mem[n++] = {f[r][15:8], 4'h0};
      exp_mem[n++] = 12'hA50; exp_mem[n++] = {f[r][7:0], 4'h0};
      for (int a = int'(f[r]); a <= int'(l[r]); a += 2) begin
        logic [15:0] v;
        v = mem_val(16'(a));
        exp_mem[n++] = 12'h5A0; exp_mem[n++] = {v[15:8], 4'h0};
        exp_mem[n++] = 12'h5A0; exp_mem[n++] = {v[7:0], 4'h0};
      end
    end
    while (n < 2048) exp_mem[n++] = 12'h000;
  endtask

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8: full word stream; optional mid-line start poke for R9
  task automatic run_line(input logic sel, input logic [15:0] w, input logic poke);
    int bad_i = -1;
    logic [11:0] bad_a = '0;
    build(sel);
    @(negedge clk); line_sel = sel; width = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < int'(w); i++) begin
      if (bad_i < 0 && (!lv || pix !== exp_mem[i])) begin bad_i = i; bad_a = pix; end
      if (poke && i == 5) begin start = 1'b1; line_sel = ~sel; width = 16'd3; end
      else start = 1'b0;
      @(negedge clk);
    end
    check(poke ? "R9 stream with mid-line start" : "R6 word stream",
          bad_i < 0, bad_a, (bad_i < 0) ? 0 : exp_mem[bad_i]);
    check("R8 lv low after width", !lv && pix == 12'h0, {lv, pix}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1
    #(CLK_PERIOD*2 + 1);
    check("R1 reset lv", lv == 1'b0, lv, 0);
    check("R1 reset pix/rd_en", pix == 12'h0 && rd_en == 1'b0, {rd_en, pix}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", !lv && pix == 12'h0 && !rd_en, {lv, rd_en, pix}, 0);

    for (int k = 0; k < NVEC; k++) run_line(VEC[k][16], VEC[k][15:0], 1'b0);

    // R9: start while active ignored, selection held
    run_line(1'b1, 16'd400, 1'b1);
    run_line(1'b0, 16'd40, 1'b1);

    // R9: zero width ignored
    @(negedge clk); width = 16'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 zero width no line", !lv && pix == 12'h0, {lv, pix}, 0);
    repeat (3) @(negedge clk);
    check("R9 zero width still idle", !lv && !rd_en, {lv, rd_en}, 0);

    // R10 idle bus zero between lines
    check("R10 idle pix zero", pix == 12'h0, pix, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule